// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds eight binary semaphore flags shared by a left and a right port. It has no data memory. Two agents use it to agree on who owns a shared resource. To request a flag, a port writes 0 on data bit 0. To release it, the port writes 1. Each side keeps its own request latch for every flag. An owner field per flag records which side holds the token, or records that the flag is free.

When a request arrives while the flag is held, it stays pending in that side's latch. When the owner releases, the token passes straight to the pending side, so the flag never shows as free in between. A read returns the flag as the reading side sees it, copied onto every data bit. It reads 0 when that side owns the token and 1 otherwise.

The read value is captured when a read starts. It is then held for as long as the read stays active, so a polling agent must drop select or output enable between polls. Everything is synchronous to one clock. When both sides request a free flag on the same edge, a fixed priority set by a parameter decides the winner.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset every flag is free, with no request pending, and reads as 1 from both ports.
- R2: Only the three lowest address bits select a flag. All higher address bits have no effect on writes or reads.
- R3: A write is accepted on the clock edge where select and write strobe are both high. Only data bit 0 is used: 0 stores a request and 1 clears that side's request. The new state is visible to reads that start on the following cycle.
- R4: When a side writes 0 to a free flag, that side reads the flag as 0 and the other side reads it as 1. A write of 1 by the non-owning side, when that side has no pending request, leaves ownership unchanged.
- R5: A 0 written by the non-owning side stays pending. When the owner writes 1, ownership moves directly to the pending side.
- R6: A flag is free only when neither side has a request stored. The write sequence L0,R0,L1,L0,R1,L1,R0,R1,L0,L1 yields the owners L,L,R,R,L,free,R,free,L,free.
- R7: A read drives the flag value onto all eight data bits, giving 8'hFF or 8'h00. The data output is 8'h00 when no read is active.
- R8: A read is active while select and output enable are high and the write strobe is low. The value is captured on the first active edge and is held unchanged until the read goes inactive.
- R9: When both sides write 0 to a free flag on the same edge, exactly one side gets the token. The parameter TIE_LEFT=1 (the default) picks the left port, and 0 picks the right port.
- R10: The eight flags are independent. A write to one flag does not change any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| l_sel_i | input | 1 | Left semaphore select |
| l_we_i | input | 1 | Left write strobe |
| l_oe_i | input | 1 | Left output enable |
| l_addr_i | input | 12 | Left address; bits 2:0 pick the flag |
| l_wdata_i | input | 8 | Left write data; bit 0 used |
| l_rdata_o | output | 8 | Left read data |
| r_sel_i | input | 1 | Right semaphore select |
| r_we_i | input | 1 | Right write strobe |
| r_oe_i | input | 1 | Right output enable |
| r_addr_i | input | 12 | Right address; bits 2:0 pick the flag |
| r_wdata_i | input | 8 | Right write data; bit 0 used |
| r_rdata_o | output | 8 | Right read data |

## Verification
A write takes effect on the edge where its strobe is sampled. A read captures on the first edge where it is active, and the captured value is on the data output from just after that edge. The bench drives each access at a falling edge and checks read data at the next falling edge, which is half a cycle after the capture. Between accesses it leaves one idle rising edge, so each read starts fresh and never sees a value held over from an earlier read. The hold test keeps the read active across several edges while the other port changes ownership, then reopens the read one cycle later and expects the new value.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_FLAGS-1:0] wr_o
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
    assign wr_o[g] = sel_i & we_i & (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_bank_pkg::*;
#(
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_l_i,
  input  logic bit_l_i,
  input  logic wr_r_i,
  input  logic bit_r_i,
  output logic view_l_o,
  output logic view_r_o
);
  logic   req_l_q, req_r_q, req_l_d, req_r_d;
  owner_e owner_q, owner_d;

  assign req_l_d = wr_l_i ? ~bit_l_i : req_l_q;
  assign req_r_d = wr_r_i ? ~bit_r_i : req_r_q;

  always_comb begin
    if (owner_q == OWN_LEFT && req_l_d)        owner_d = OWN_LEFT;
    else if (owner_q == OWN_RIGHT && req_r_d)  owner_d = OWN_RIGHT;
    else if (req_l_d && req_r_d)               owner_d = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;
    else if (req_l_d)                          owner_d = OWN_LEFT;
    else if (req_r_d)                          owner_d = OWN_RIGHT;
    else                                       owner_d = OWN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      owner_q <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      owner_q <= owner_d;
    end
  end

  assign view_l_o = (owner_q != OWN_LEFT);
  assign view_r_o = (owner_q != OWN_RIGHT);

  // R6: free implies no stored request
  a_r6_free_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE) |-> (!req_l_q && !req_r_q));
  // R9: tie on a free flag grants exactly one side
  a_r9_tie_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && wr_l_i && !bit_l_i && wr_r_i && !bit_r_i)
      |=> (owner_q == (TIE_LEFT ? OWN_LEFT : OWN_RIGHT)));
  // R4: owner keeps token unless it releases
  a_r4_owner_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && !(wr_l_i && bit_l_i)) |=> (owner_q == OWN_LEFT));
  // R5: release with pending request hands over directly
  a_r5_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && req_r_q && wr_l_i && bit_l_i && !(wr_r_i && bit_r_i))
      |=> (owner_q == OWN_RIGHT));
  a_r5_never_both_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    view_l_o || view_r_o);
endmodule

// File: rtl/sem_read_hold.sv
module sem_read_hold #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 oe_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_FLAGS-1:0] view_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic act, act_q, held_q;

  assign act = sel_i & oe_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      held_q <= 1'b1;
    end else begin
      act_q <= act;
      if (act && !act_q) held_q <= view_i[idx_i];
    end
  end

  assign rdata_o = act_q ? {DATA_W{held_q}} : '0;

  // R8: captured value frozen while read stays active
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && act) |=> $stable(rdata_o));
  // R7: flag spread on all bits
  a_r7_spread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o == '0) || (rdata_o == '1));
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter bit TIE_LEFT  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sel_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int IDX_W = $clog2(NUM_FLAGS);

  logic [IDX_W-1:0]     l_idx, r_idx;
  logic [NUM_FLAGS-1:0] l_wr, r_wr, l_view, r_view;

  // R2: upper address bits are not decoded
  assign l_idx = l_addr_i[IDX_W-1:0];
  assign r_idx = r_addr_i[IDX_W-1:0];

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_l_dec (
    .sel_i(l_sel_i), .we_i(l_we_i), .idx_i(l_idx), .wr_o(l_wr));
  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_r_dec (
    .sel_i(r_sel_i), .we_i(r_we_i), .idx_i(r_idx), .wr_o(r_wr));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_l_i   (l_wr[g]),
      .bit_l_i  (l_wdata_i[0]),
      .wr_r_i   (r_wr[g]),
      .bit_r_i  (r_wdata_i[0]),
      .view_l_o (l_view[g]),
      .view_r_o (r_view[g])
    );
  end

  sem_read_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_l_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(l_sel_i), .oe_i(l_oe_i), .we_i(l_we_i),
    .idx_i(l_idx), .view_i(l_view), .rdata_o(l_rdata_o));
  sem_read_hold #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_r_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(r_sel_i), .oe_i(r_oe_i), .we_i(r_we_i),
    .idx_i(r_idx), .view_i(r_view), .rdata_o(r_rdata_o));

  // R10: a write touches only its addressed flag
  a_r10_onehot_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(l_wr) && $onehot0(r_wr));
  // R4: left and right never both see ownership
  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_view | r_view) == '1);
endmodule

// File: tb/tb_sem_flag_bank.sv
module tb_sem_flag_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_we = 0, l_oe = 0, r_sel = 0, r_we = 0, r_oe = 0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wd = '0, r_wd = '0, l_rd, r_rd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sem_flag_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sel_i(l_sel), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_sel_i(r_sel), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_rdata_o(r_rd));

  // entry: {side(1=right), data bit, expected owner 0 free 1 left 2 right}
  localparam logic [3:0] SEQ [10] = '{
    {1'b0,1'b0,2'd1}, {1'b1,1'b0,2'd1}, {1'b0,1'b1,2'd2}, {1'b0,1'b0,2'd2},
    {1'b1,1'b1,2'd1}, {1'b0,1'b1,2'd0}, {1'b1,1'b0,2'd2}, {1'b1,1'b1,2'd0},
    {1'b0,1'b0,2'd1}, {1'b0,1'b1,2'd0}};

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input bit side, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    if (side) begin r_sel = 1; r_we = 1; r_addr = a; r_wd = d; end
    else      begin l_sel = 1; l_we = 1; l_addr = a; l_wd = d; end
    @(negedge clk);
    r_sel = 0; r_we = 0; l_sel = 0; l_we = 0;
  endtask

  task automatic do_rd(input bit side, input logic [11:0] a, input logic exp, input string req);
    @(negedge clk);
    if (side) begin r_sel = 1; r_oe = 1; r_addr = a; end
    else      begin l_sel = 1; l_oe = 1; l_addr = a; end
    @(negedge clk);
    check8(req, side ? r_rd : l_rd, {8{exp}});
    r_sel = 0; r_oe = 0; l_sel = 0; l_oe = 0;
  endtask

  task automatic chk_owner(input logic [11:0] a, input logic [1:0] own, input string req);
    do_rd(1'b0, a, own != 2'd1, req);
    do_rd(1'b1, a, own != 2'd2, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: idle outputs zero
    check8("R7 idle left", l_rd, 8'h00);
    check8("R7 idle right", r_rd, 8'h00);
    // R1: all free after reset
    for (int i = 0; i < 8; i++) chk_owner(12'(i), 2'd0, "R1 reset free");

    // R6/R5: sequence table on flag 1
    for (int i = 0; i < 10; i++) begin
      do_wr(SEQ[i][3], 12'h001, {7'h0, SEQ[i][2]});
      chk_owner(12'h001, SEQ[i][1:0], "R6 sequence");
    end

    // R3: only bit 0 used; R2: upper address ignored
    do_wr(1'b0, 12'hA43, 8'hFE);
    chk_owner(12'h003, 2'd1, "R3 bit0 request / R2 high addr");
    chk_owner(12'h7F3, 2'd1, "R2 read high addr");
    // R10: neighbours untouched
    chk_owner(12'h002, 2'd0, "R10 flag2 free");
    chk_owner(12'h004, 2'd0, "R10 flag4 free");
    // R4: non-owner release has no effect
    do_wr(1'b1, 12'h003, 8'h01);
    chk_owner(12'h003, 2'd1, "R4 non-owner release");
    do_wr(1'b0, 12'h803, 8'h01);
    chk_owner(12'h003, 2'd0, "R3 bit0 release");

    // R9: simultaneous request on flag 7
    @(negedge clk);
    l_sel = 1; l_we = 1; l_addr = 12'h007; l_wd = 8'h00;
    r_sel = 1; r_we = 1; r_addr = 12'h007; r_wd = 8'h00;
    @(negedge clk);
    l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
    chk_owner(12'h007, 2'd1, "R9 tie to left");
    do_wr(1'b0, 12'h007, 8'h01);
    chk_owner(12'h007, 2'd2, "R5 tie loser pending takes token");
    do_wr(1'b1, 12'h007, 8'h01);
    chk_owner(12'h007, 2'd0, "R6 free after both release");

    // R8: hold while active
    do_wr(1'b1, 12'h006, 8'h00);
    do_wr(1'b0, 12'h006, 8'h00);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_addr = 12'h006;
    @(negedge clk);
    check8("R8 capture", l_rd, 8'hFF);
    r_sel = 1; r_we = 1; r_addr = 12'h006; r_wd = 8'h01;
    @(negedge clk);
    r_sel = 0; r_we = 0;
    repeat (2) @(negedge clk);
    check8("R8 held after handoff", l_rd, 8'hFF);
    l_oe = 0;
    @(negedge clk);
    check8("R7 inactive zero", l_rd, 8'h00);
    l_oe = 1;
    @(negedge clk);
    check8("R8 reread new value", l_rd, 8'h00);
    l_sel = 0; l_oe = 0;
    chk_owner(12'h006, 2'd1, "R5 handoff flag6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule